// File: doc/BRIEF.md
# Signed Halfword Multiply-Accumulate Unit

This block is a single-cycle datapath that multiplies signed operands and adds a 32-bit accumulator to the product. A 3-bit opcode picks one of six operations. Four of them multiply a 16-bit half of the first operand by a 16-bit half of the second. The other two multiply the whole first operand by a 16-bit half of the second and keep only the upper 32 bits of the 48-bit product.

The sum wraps modulo 2^32 and is never saturated. A signed overflow in the accumulate addition sets a sticky overflow flag. Only a dedicated synchronous clear input lowers that flag.

The unit accepts one operation per cycle. An operation is accepted only when the input valid is high, the condition-pass input is high and the opcode is defined. The result and its strobe appear one clock after acceptance.

Top module: `hmac_unit`

## Requirements
- R1: Opcode 000 returns sext16(opa[15:0]) * sext16(opb[15:0]) + acc in 32 bits.
- R2: The first-operand half is picked by opcode bit 1 and the second-operand half by opcode bit 0, where 0 means bits [15:0] and 1 means bits [31:16]. Opcode 001 takes opa bottom and opb top, 010 takes opa top and opb bottom, and 011 takes both tops.
- R3: In the halfword modes, changing the half of an operand that is not selected leaves the result unchanged.
- R4: Opcode 100 returns bits [47:16] of the 48-bit product sext32(opa) * sext16(opb[15:0]), plus acc.
- R5: Opcode 101 returns the same as R4, but with opb[31:16] as the halfword.
- R6: The result wraps modulo 2^32 when the signed sum leaves the 32-bit range.
- R7: ovf_flag rises after an accepted operation only when the accumulate addition overflows in signed 32-bit arithmetic. A product with no addition never raises it; for example, 0x8000 * 0x8000 + 0 does not.
- R8: ovf_flag is sticky. Further operations never clear it. sticky_clr clears it on the next edge, but an overflowing operation accepted in the same cycle as the clear leaves it set.
- R9: Opcodes 110 and 111 give no result_valid strobe, and they leave result and ovf_flag unchanged.
- R10: With cond_ok low, a valid input gives no strobe, and it leaves result and ovf_flag unchanged.
- R11: result_valid is high for exactly the cycle after each accepted operation, and low otherwise. result holds its value between accepted operations.
- R12: A synchronous active-high rst clears result, result_valid and ovf_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sticky_clr | input | 1 | Synchronous clear of the overflow flag |
| in_valid | input | 1 | Operation request |
| cond_ok | input | 1 | Condition passed; low cancels the request |
| opcode | input | 3 | Operation select |
| opa | input | 32 | First multiplicand |
| opb | input | 32 | Second multiplicand, supplies a halfword |
| acc | input | 32 | Accumulator addend |
| result | output | 32 | Registered sum |
| result_valid | output | 1 | One-cycle strobe for a new result |
| ovf_flag | output | 1 | Sticky accumulate-overflow flag |

## Verification
The assertions assume that the inputs are driven to known values and are stable across each rising edge. They also assume that rst is held for at least one edge before any check counts. The bench changes every input on the falling edge, holds rst for several cycles at the start, and raises in_valid for one cycle per operation. Undefined opcodes and a low cond_ok are applied on purpose, because the unit must tolerate them rather than assume they never occur.

// File: rtl/hmac_pkg.sv
package hmac_pkg;
    typedef enum logic [2:0] {
        OP_BB = 3'b000,
        OP_BT = 3'b001,
        OP_TB = 3'b010,
        OP_TT = 3'b011,
        OP_WB = 3'b100,
        OP_WT = 3'b101
    } hmac_op_e;
endpackage

// File: rtl/hmac_half_pick.sv
module hmac_half_pick #(
    parameter int DATA_W = 32
) (
    input  logic [2:0]                 op,
    input  logic [DATA_W-1:0]          opa,
    input  logic [DATA_W-1:0]          opb,
    output logic signed [DATA_W/2-1:0] a_half,
    output logic signed [DATA_W/2-1:0] b_half,
    output logic                       word_mode,
    output logic                       legal
);
    import hmac_pkg::*;
    localparam int HALF_W = DATA_W / 2;

    // bit 1 picks the opa half, bit 0 picks the opb half (R2)
    assign a_half    = op[1] ? opa[DATA_W-1:HALF_W] : opa[HALF_W-1:0];
    assign b_half    = op[0] ? opb[DATA_W-1:HALF_W] : opb[HALF_W-1:0];
    assign word_mode = op[2];
    assign legal     = (op <= OP_WT);
endmodule

// File: rtl/hmac_mul.sv
module hmac_mul #(
    parameter int DATA_W = 32
) (
    input  logic                       word_mode,
    input  logic [DATA_W-1:0]          opa,
    input  logic signed [DATA_W/2-1:0] a_half,
    input  logic signed [DATA_W/2-1:0] b_half,
    output logic [DATA_W-1:0]          addend
);
    localparam int HALF_W = DATA_W / 2;
    localparam int WIDE_W = DATA_W + HALF_W;

    logic signed [DATA_W-1:0] ax, bx, hh, opa_s;
    logic signed [WIDE_W-1:0] ow, bw, wh;
    logic                     unused_lo;

    assign ax        = DATA_W'(a_half);
    assign bx        = DATA_W'(b_half);
    assign hh        = ax * bx;
    assign opa_s     = opa;
    assign ow        = WIDE_W'(opa_s);
    assign bw        = WIDE_W'(b_half);
    assign wh        = ow * bw;
    assign unused_lo = ^wh[HALF_W-1:0];
    assign addend    = word_mode ? wh[WIDE_W-1:HALF_W] : hh;

    // R7: a halfword product always fits the signed DATA_W range
    always_comb begin
        a_r7_half_product_fits: assert (hh[DATA_W-1] == hh[DATA_W-2] ||
                                        hh == (DATA_W'(1) << (DATA_W-2)));
    end
endmodule

// File: rtl/hmac_add.sv
module hmac_add #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    output logic [DATA_W-1:0] sum,
    output logic              ovf
);
    assign sum = x + y;
    // same-sign addends whose sum flips sign (R6, R7)
    assign ovf = (x[DATA_W-1] == y[DATA_W-1]) && (sum[DATA_W-1] != x[DATA_W-1]);
endmodule

// File: rtl/hmac_unit.sv
module hmac_unit #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sticky_clr,
    input  logic              in_valid,
    input  logic              cond_ok,
    input  logic [2:0]        opcode,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] result,
    output logic              result_valid,
    output logic              ovf_flag
);
    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              vld;
        logic              ovf;
    } state_t;

    state_t st_d, st_q;

    logic signed [HALF_W-1:0] a_half, b_half;
    logic                     word_mode, legal, accept, add_ovf;
    logic [DATA_W-1:0]        addend, sum;

    hmac_half_pick #(.DATA_W(DATA_W)) u_pick (
        .op(opcode), .opa(opa), .opb(opb),
        .a_half(a_half), .b_half(b_half),
        .word_mode(word_mode), .legal(legal)
    );

    hmac_mul #(.DATA_W(DATA_W)) u_mul (
        .word_mode(word_mode), .opa(opa),
        .a_half(a_half), .b_half(b_half), .addend(addend)
    );

    hmac_add #(.DATA_W(DATA_W)) u_add (
        .x(addend), .y(acc), .sum(sum), .ovf(add_ovf)
    );

    assign accept = in_valid && cond_ok && legal;

    always_comb begin
        st_d     = st_q;
        st_d.vld = accept;
        if (accept) begin
            st_d.res = sum;
        end
        st_d.ovf = (st_q.ovf && !sticky_clr) || (accept && add_ovf);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result       = st_q.res;
    assign result_valid = st_q.vld;
    assign ovf_flag     = st_q.ovf;

    a_r11_strobe_cause: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> $past(in_valid && cond_ok && opcode <= 3'b101));

    a_r9_no_strobe_undefined: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode[2] && opcode[1]) |=> !result_valid);

    a_r10_hold_result: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(result));

    a_r8_sticky_keep: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !sticky_clr) |=> ovf_flag);

    a_r8_clear_works: assert property (@(posedge clk) disable iff (rst)
        (sticky_clr && !accept) |=> !ovf_flag);

    a_r7_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> $past(accept));
endmodule

// File: tb/hmac_unit_bench.sv
module hmac_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, sticky_clr, in_valid, cond_ok;
    logic [2:0]  opcode;
    logic [31:0] opa, opb, acc;
    logic [31:0] result;
    logic        result_valid, ovf_flag;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hmac_unit u_hmac_unit (
        .clk(clk), .rst(rst), .sticky_clr(sticky_clr), .in_valid(in_valid),
        .cond_ok(cond_ok), .opcode(opcode), .opa(opa), .opb(opb), .acc(acc),
        .result(result), .result_valid(result_valid), .ovf_flag(ovf_flag)
    );

    // reference: {overflow, sum} from wide integer arithmetic
    function automatic logic [32:0] model(input logic [2:0] op,
                                          input logic [31:0] n, m, a);
        longint p, s;
        logic [15:0] nh, mh;
        logic ov;
        nh = op[1] ? n[31:16] : n[15:0];
        mh = op[0] ? m[31:16] : m[15:0];
        if (op[2]) p = (longint'($signed(n)) * longint'($signed(mh))) >>> 16;
        else       p = longint'($signed(nh)) * longint'($signed(mh));
        s  = longint'($signed(a)) + p;
        ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        return {ov, s[31:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] got, exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // drive one request at a falling edge, return after the next falling edge
    task automatic issue(input logic [2:0] op, input logic [31:0] n, m, a,
                         input logic c, input logic clr);
        @(negedge clk);
        opcode = op; opa = n; opb = m; acc = a;
        in_valid = 1'b1; cond_ok = c; sticky_clr = clr;
        @(negedge clk);
        in_valid = 1'b0; cond_ok = 1'b1; sticky_clr = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        sticky_clr = 1'b1;
        @(negedge clk);
        sticky_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R12 result", result, 32'h0);
        check("R12 valid", {31'b0, result_valid}, 32'h0);
        check("R12 flag", {31'b0, ovf_flag}, 32'h0);
    endtask

    task automatic t_half_modes();
        logic [32:0] e;
        for (int k = 0; k < 4; k++) begin
            issue(3'(k), 32'hFFFE_0003, 32'h0005_FFF9, 32'd100, 1'b1, 1'b0);
            e = model(3'(k), 32'hFFFE_0003, 32'h0005_FFF9, 32'd100);
            check(k == 0 ? "R1 BB" : "R2 half select", result, e[31:0]);
            check("R11 strobe", {31'b0, result_valid}, 32'h1);
        end
        check("R7 no flag", {31'b0, ovf_flag}, 32'h0);
        // explicit value: top(-2)*top(5)+100 = 90
        check("R2 TT literal", result, 32'd90);
    endtask

    task automatic t_unselected();
        issue(3'b000, 32'h1234_0003, 32'hABCD_FFF9, 32'd7, 1'b1, 1'b0);
        check("R3 BB ignores tops", result, 32'(7 - 21));
        issue(3'b011, 32'hFFFE_7777, 32'h0005_8888, 32'd7, 1'b1, 1'b0);
        check("R3 TT ignores bottoms", result, 32'(7 - 10));
    endtask

    task automatic t_word();
        logic [32:0] e;
        issue(3'b100, 32'h1234_5678, 32'h7FFF_8000, 32'd1, 1'b1, 1'b0);
        check("R4 WB literal", result, 32'(1 - 32'h091A_2B3C));
        issue(3'b101, 32'h8765_4321, 32'h1234_0000, 32'hFFFF_0000, 1'b1, 1'b0);
        e = model(3'b101, 32'h8765_4321, 32'h1234_0000, 32'hFFFF_0000);
        check("R5 WT", result, e[31:0]);
        check("R11 strobe word", {31'b0, result_valid}, 32'h1);
    endtask

    task automatic t_overflow();
        issue(3'b000, 32'h0000_8000, 32'h0000_8000, 32'h0, 1'b1, 1'b0);
        check("R7 product alone", result, 32'h4000_0000);
        check("R7 no flag on product", {31'b0, ovf_flag}, 32'h0);
        issue(3'b000, 32'h0000_8000, 32'h0000_8000, 32'h4000_0000, 1'b1, 1'b0);
        check("R6 wrap", result, 32'h8000_0000);
        check("R7 flag set", {31'b0, ovf_flag}, 32'h1);
        issue(3'b000, 32'h1, 32'h1, 32'h1, 1'b1, 1'b0);
        check("R8 sticky after op", {31'b0, ovf_flag}, 32'h1);
        clear_flag();
        check("R8 clear", {31'b0, ovf_flag}, 32'h0);
        // negative side: 0x80000000 + (-1*1)
        issue(3'b000, 32'h0000_FFFF, 32'h1, 32'h8000_0000, 1'b1, 1'b1);
        check("R6 negative wrap", result, 32'h7FFF_FFFF);
        check("R8 set beats clear", {31'b0, ovf_flag}, 32'h1);
    endtask

    task automatic t_undefined();
        logic [31:0] keep;
        keep = result;
        for (int k = 6; k < 8; k++) begin
            issue(3'(k), 32'h0000_8000, 32'h0000_8000, 32'h4000_0000, 1'b1, 1'b0);
            check("R9 no strobe", {31'b0, result_valid}, 32'h0);
            check("R9 result held", result, keep);
            check("R9 flag held", {31'b0, ovf_flag}, 32'h1);
        end
    endtask

    task automatic t_cond();
        logic [31:0] keep;
        clear_flag();
        keep = result;
        issue(3'b000, 32'h0000_8000, 32'h0000_8000, 32'h4000_0000, 1'b0, 1'b0);
        check("R10 no strobe", {31'b0, result_valid}, 32'h0);
        check("R10 result held", result, keep);
        check("R10 flag held", {31'b0, ovf_flag}, 32'h0);
    endtask

    task automatic t_latency();
        issue(3'b001, 32'h3, 32'h0002_0000, 32'h0, 1'b1, 1'b0);
        check("R11 one-cycle result", result, 32'd6);
        @(negedge clk);
        check("R11 strobe drops", {31'b0, result_valid}, 32'h0);
        check("R11 result holds", result, 32'd6);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; sticky_clr = 1'b0; in_valid = 1'b0; cond_ok = 1'b1;
        opcode = 3'b000; opa = '0; opb = '0; acc = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_half_modes();
        t_unselected();
        t_word();
        t_overflow();
        t_undefined();
        t_cond();
        t_latency();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule